// File: doc/BRIEF.md
# Nibble-Indexed Byte Shuffle Unit

This block forms one 64-bit result by picking eight bytes out of a sixteen-byte pool made of two 64-bit source operands. Each result byte has its own 4-bit index, and the eight indices come packed together as a 32-bit selector word. The selector word sits in the upper half of a 64-bit status word that the block receives unchanged from its surroundings. Whatever produces that selector is outside the block.

The unit is purely combinational. It has no clock, no state and no handshake. The result follows its inputs within the same cycle. Use it as an execute-stage function for byte permutation, alignment, byte reversal and byte broadcast.

Each output lane is a 16-to-1 byte multiplexer fed by its own index field. A parameter chooses how the multiplexer is built: a one-hot AND-OR network or an indexed select. Lane width, lane count and the position of the selector word are parameters, and elaboration-time checks guard them.

Top module: `byte_shuffle_unit`

## Requirements
- R1: The selector word is taken from `status_i[63:32]` only. Any change to `status_i[31:0]` leaves `result_o` unchanged.
- R2: Pool index k in 0..7 names byte `src_a_i[63-8k -: 8]`, so index 0 is the most significant byte of source A. Pool index k in 8..15 names byte `src_b_i[127-8k -: 8]`. Selector `32'h76543210` therefore returns `src_a_i`, and `32'hFEDCBA98` returns `src_b_i`.
- R3: Result byte `result_o[8i+7:8i]`, for i = 0..7, is the pool byte named by selector bits [31-4i:28-4i], which are `status_i[63-4i:60-4i]`. The lowest result byte therefore uses the top nibble.
- R4: Each index field is an unsigned 4-bit number, so all 16 pool bytes are reachable. When several fields hold the same index, the result carries copies of that byte; when all eight fields match, every result byte is that byte.
- R5: The unit is combinational. A change on any input shows on `result_o` without a clock edge.
- R6: With all inputs at zero, `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| status_i | input | 64 | Status word; bits [63:32] hold the eight packed 4-bit indices |
| src_a_i | input | 64 | First source operand; supplies pool indices 0..7 |
| src_b_i | input | 64 | Second source operand; supplies pool indices 8..15 |
| result_o | output | 64 | Shuffled result |

## Verification
The assertions inside the RTL are checked whenever the inputs change:
- The pass-through selectors return source A or source B unchanged.
- A uniform selector yields eight identical bytes.
- The lowest result byte matches the byte named by the top nibble.
- In the one-hot variant, each lane's decode is exactly one-hot.

Only the bench's scenarios can show the rest:
- The low status half has no effect.
- Each of the sixteen indices reaches each lane.
- Byte reversal and mixed random selectors give the right result.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

   typedef enum logic [0:0] {
      MUX_ONEHOT = 1'b0,
      MUX_INDEX  = 1'b1
   } mux_style_e;

endpackage

// File: rtl/byte_pool.sv
module byte_pool #(
   parameter int LANE_W = 8,
   parameter int LANES  = 8
) (
   input  logic [LANE_W*LANES-1:0] src_hi_i,
   input  logic [LANE_W*LANES-1:0] src_lo_i,
   output logic [LANE_W-1:0]       pool_o [2*LANES]
);
   localparam int POOL_N = 2 * LANES;
   localparam int CAT_W  = LANE_W * POOL_N;

   logic [CAT_W-1:0] cat;
   assign cat = {src_hi_i, src_lo_i};

   // Index 0 is the most significant byte of the concatenation.
   for (genvar k = 0; k < POOL_N; k++) begin : g_pool
      assign pool_o[k] = cat[(POOL_N-1-k)*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/sel_decoder.sv
module sel_decoder #(
   parameter int SEL_W    = 4,
   parameter int LANES    = 8,
   parameter int STATUS_W = 64,
   parameter int MASK_LSB = 32
) (
   input  logic [STATUS_W-1:0] status_i,
   output logic [SEL_W-1:0]    sel_o [LANES]
);
   localparam int MASK_W = SEL_W * LANES;

   if (MASK_LSB + MASK_W > STATUS_W) begin : g_bad_span
      $error("selector word does not fit in the status width");
   end

   // Output lane i takes the nibble counted from the top of the selector word.
   for (genvar i = 0; i < LANES; i++) begin : g_field
      assign sel_o[i] = status_i[MASK_LSB + (LANES-1-i)*SEL_W +: SEL_W];
   end

   // Status bits outside the selector word are deliberately unused.
   if (MASK_LSB > 0) begin : g_lo
      logic unused_status_lo;
      assign unused_status_lo = ^status_i[MASK_LSB-1:0];
   end
   if (MASK_LSB + MASK_W < STATUS_W) begin : g_hi
      logic unused_status_hi;
      assign unused_status_hi = ^status_i[STATUS_W-1:MASK_LSB+MASK_W];
   end
endmodule

// File: rtl/lane_mux.sv
module lane_mux #(
   parameter int                     LANE_W    = 8,
   parameter int                     POOL_N    = 16,
   parameter int                     SEL_W     = 4,
   parameter shuf_pkg::mux_style_e   MUX_STYLE = shuf_pkg::MUX_ONEHOT
) (
   input  logic [LANE_W-1:0] pool_i [POOL_N],
   input  logic [SEL_W-1:0]  sel_i,
   output logic [LANE_W-1:0] lane_o
);
   if ((1 << SEL_W) != POOL_N) begin : g_bad_sel
      $error("selector width must address the pool exactly");
   end

   if (MUX_STYLE == shuf_pkg::MUX_ONEHOT) begin : g_onehot
      logic [POOL_N-1:0] hot;

      always_comb begin
         hot = '0;
         for (int k = 0; k < POOL_N; k++) begin
            hot[k] = (sel_i == SEL_W'(k));
         end
      end

      always_comb begin
         lane_o = '0;
         for (int k = 0; k < POOL_N; k++) begin
            lane_o = lane_o | (pool_i[k] & {LANE_W{hot[k]}});
         end
      end

      // R4: every index value decodes to exactly one pool byte
      always_comb begin
         assert_onehot_decode_R4: assert ($onehot(hot))
            else $error("lane decode is not one-hot");
      end
   end else begin : g_index
      assign lane_o = pool_i[sel_i];
   end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit #(
   parameter int                   LANE_W    = 8,
   parameter int                   LANES     = 8,
   parameter int                   STATUS_W  = 64,
   parameter int                   MASK_LSB  = 32,
   parameter shuf_pkg::mux_style_e MUX_STYLE = shuf_pkg::MUX_ONEHOT
) (
   input  logic [STATUS_W-1:0]     status_i,
   input  logic [LANE_W*LANES-1:0] src_a_i,
   input  logic [LANE_W*LANES-1:0] src_b_i,
   output logic [LANE_W*LANES-1:0] result_o
);
   localparam int OP_W   = LANE_W * LANES;
   localparam int POOL_N = 2 * LANES;
   localparam int SEL_W  = $clog2(POOL_N);
   localparam int MASK_W = SEL_W * LANES;

   if (LANE_W < 1 || LANES < 1) begin : g_bad_dims
      $error("lane width and lane count must be positive");
   end
   if ((1 << SEL_W) != POOL_N) begin : g_bad_pool
      $error("pool size must be a power of two");
   end

   logic [LANE_W-1:0] pool [POOL_N];
   logic [SEL_W-1:0]  sel  [LANES];

   byte_pool #(.LANE_W(LANE_W), .LANES(LANES)) u_pool (
      .src_hi_i (src_a_i),
      .src_lo_i (src_b_i),
      .pool_o   (pool)
   );

   sel_decoder #(
      .SEL_W(SEL_W), .LANES(LANES), .STATUS_W(STATUS_W), .MASK_LSB(MASK_LSB)
   ) u_dec (
      .status_i (status_i),
      .sel_o    (sel)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_mux #(
         .LANE_W(LANE_W), .POOL_N(POOL_N), .SEL_W(SEL_W), .MUX_STYLE(MUX_STYLE)
      ) u_mux (
         .pool_i (pool),
         .sel_i  (sel[i]),
         .lane_o (result_o[i*LANE_W +: LANE_W])
      );
   end

   // Assertion helpers, derived from the ports only.
   logic [SEL_W-1:0]      top_nib;
   logic [2*OP_W-1:0]     cat_shift;
   logic                  pass_a, pass_b, uniform;

   always_comb begin
      top_nib   = status_i[MASK_LSB + MASK_W - 1 -: SEL_W];
      cat_shift = {src_a_i, src_b_i} >> ((POOL_N - 1 - int'(top_nib)) * LANE_W);
      pass_a  = 1'b1;
      pass_b  = 1'b1;
      uniform = 1'b1;
      for (int j = 0; j < LANES; j++) begin
         if (status_i[MASK_LSB + j*SEL_W +: SEL_W] != SEL_W'(j))         pass_a  = 1'b0;
         if (status_i[MASK_LSB + j*SEL_W +: SEL_W] != SEL_W'(j + LANES)) pass_b  = 1'b0;
         if (status_i[MASK_LSB + j*SEL_W +: SEL_W] != top_nib)           uniform = 1'b0;
      end
   end

   always_comb begin
      assert_pass_src_a_R2: assert (!pass_a || result_o == src_a_i)
         else $error("pass-through selector did not return source A");
      assert_pass_src_b_R2: assert (!pass_b || result_o == src_b_i)
         else $error("pass-through selector did not return source B");
      assert_lowest_lane_R3: assert (result_o[LANE_W-1:0] == cat_shift[LANE_W-1:0])
         else $error("lowest result byte not taken from the top nibble");
      assert_broadcast_R4: assert (!uniform || result_o == {LANES{result_o[LANE_W-1:0]}})
         else $error("uniform selector did not broadcast one byte");
   end
endmodule

// File: tb/tb_byte_shuffle_unit.sv
module tb_byte_shuffle_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [63:0] status, src_a, src_b;
   logic [63:0] result;
   int          n_checks = 0;
   int          n_fails  = 0;
   bit          done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_shuffle_unit dut (
      .status_i (status),
      .src_a_i  (src_a),
      .src_b_i  (src_b),
      .result_o (result)
   );

   // Reference built from the requirement text (R2, R3).
   function automatic logic [63:0] model(input logic [63:0] st, input logic [63:0] a,
                                          input logic [63:0] b);
      logic [63:0] r;
      int n;
      r = '0;
      for (int i = 0; i < 8; i++) begin
         n = int'(st[63-4*i -: 4]);
         if (n < 8) r[8*i +: 8] = a[63-8*n -: 8];
         else       r[8*i +: 8] = b[127-8*n -: 8];
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // Drive on the falling edge, sample one time unit later (no clock in the path: R5).
   task automatic apply(input logic [63:0] st, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      status = st; src_a = a; src_b = b;
      #1;
   endtask

   task automatic t_zero;
      apply('0, '0, '0);
      check("R6 zero inputs", result, 64'h0);
   endtask

   task automatic t_pass;
      apply({32'h76543210, 32'h0}, 64'h0102030405060708, 64'h1112131415161718);
      check("R2 pass source A", result, 64'h0102030405060708);
      apply({32'hFEDCBA98, 32'h0}, 64'h0102030405060708, 64'h1112131415161718);
      check("R2 pass source B", result, 64'h1112131415161718);
   endtask

   task automatic t_reverse;
      apply({32'h01234567, 32'h0}, 64'hA1B2C3D4E5F60718, 64'h0);
      check("R3 byte reverse A", result, 64'h1807F6E5D4C3B2A1);
      apply({32'h89ABCDEF, 32'h0}, 64'h0, 64'h0011223344556677);
      check("R3 byte reverse B", result, 64'h7766554433221100);
   endtask

   task automatic t_broadcast;
      logic [63:0] a, b;
      a = 64'h8081828384858687;
      b = 64'h88898A8B8C8D8E8F;
      for (int k = 0; k < 16; k++) begin
         apply({{8{4'(k)}}, 32'h0}, a, b);
         check("R4 broadcast", result, {8{8'(8'h80 + k)}});
      end
   endtask

   task automatic t_lane_walk;
      // One lane picks index 15; all others pick index 0.
      for (int i = 0; i < 8; i++) begin
         logic [31:0] m;
         logic [63:0] exp;
         m = '0;
         m[31-4*i -: 4] = 4'hF;
         exp = {8{8'hAA}};
         exp[8*i +: 8] = 8'h55;
         apply({m, 32'h0}, 64'hAA00000000000000, 64'h0000000000000055);
         check("R3 lane position", result, exp);
      end
   endtask

   task automatic t_low_ignored;
      logic [63:0] ref_v;
      apply({32'h3C9E1F07, 32'h0}, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210);
      ref_v = result;
      check("R1 baseline", ref_v, model({32'h3C9E1F07, 32'h0}, src_a, src_b));
      apply({32'h3C9E1F07, 32'hFFFFFFFF}, src_a, src_b);
      check("R1 low half set", result, ref_v);
      apply({32'h3C9E1F07, 32'h5A5AA5A5}, src_a, src_b);
      check("R1 low half pattern", result, ref_v);
   endtask

   task automatic t_random;
      for (int t = 0; t < 200; t++) begin
         logic [63:0] st, a, b;
         st = {$urandom, $urandom};
         a  = {$urandom, $urandom};
         b  = {$urandom, $urandom};
         apply(st, a, b);
         check("R3 random selector", result, model(st, a, b));
      end
   endtask

   task automatic t_comb;
      // R5: change only the sources mid-cycle, with no clock edge in between.
      @(negedge clk);
      status = {32'h76543210, 32'h0};
      src_a  = 64'h1111111111111111;
      #1;
      check("R5 first value", result, 64'h1111111111111111);
      src_a = 64'h2222222222222222;
      #1;
      check("R5 follows input", result, 64'h2222222222222222);
   endtask

   initial begin
      status = '0; src_a = '0; src_b = '0;
      t_zero();
      t_pass();
      t_reverse();
      t_broadcast();
      t_lane_walk();
      t_low_ignored();
      t_random();
      t_comb();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule